// File: doc/BRIEF.md
# Programmable I2C SCL Clock Generator

This block derives the serial clock for an I2C master from the system clock. A single 32-bit configuration word, written and read through a plain write-strobe/read-data port, holds a 7-bit divider value and a speed-mode bit. While the generator is enabled it produces a free-running clock that is low for six time units and high for four. Each unit lasts 2 × (1 + divider) system clocks, so one full serial clock cycle takes 20 × (1 + divider) system clocks.

A one-cycle tick marks every edge of the generated clock, including the first falling edge after the generator is enabled. A master controller can use this tick to place START, data and STOP events. The divider is sampled only at the boundary between serial clock cycles, so reprogramming never shortens or stretches a phase already in progress. The speed-mode bit is write-only in the readback, but its stored value drives a mode output for the rest of the master.

Top module: `scl_clkgen_top`

## Requirements
- R1: After reset the configuration readback is 0x00000001, the mode output is 0, the clock output is high and the tick is 0.
- R2: A write sets the divider from bits 6:0 of the write data. From the next cycle, readback bits 6:0 return the written divider, and bits 31:7 read 0 whatever was written.
- R3: The mode output holds bit 7 of the most recent write, starting the cycle after that write.
- R4: While enabled with effective divider D, the clock output is low for 6 × 2 × (1+D) system clocks and then high for 4 × 2 × (1+D) system clocks, and this cycle repeats.
- R5: The tick is high for exactly one system clock, in the first cycle of each new clock-output level while enabled. This includes the first low phase after enable. It is low at all other times.
- R6: A divider written during a serial clock cycle takes effect only from the first low phase of the following serial clock cycle.
- R7: A written divider of 0 is stored and read back as 0, but it is timed exactly as a divider of 1.
- R8: While the enable input is low, the clock output is high and the tick is 0. The divider in use follows the stored value.
- R9: When the enable input is sampled high after being low, the clock output goes low in the following cycle and that first unit lasts a full 2 × (1+D) system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_data | input | 32 | Configuration write data (bit 7 mode, bits 6:0 divider) |
| cfg_rd_data | output | 32 | Configuration readback |
| gen_enable | input | 1 | Generator enable; low holds the clock released |
| scl_o | output | 1 | Generated serial clock level |
| phase_tick | output | 1 | One-cycle pulse at each serial clock edge |
| hs_mode | output | 1 | Stored speed-mode bit |

## Verification
Readback and the mode output are due one clock after the write edge. The clock level and the tick change at the same edge: either the one where the enable is first sampled high, or the one where a unit counter wraps. None of these outputs has a combinational path from any input. The bench keeps a behavioural model that counts elapsed system clocks within the serial cycle and advances it at each rising edge from the inputs held there. It compares every output at the following falling edge, so each result is checked in exactly the cycle it is due. Mid-cycle divider writes, a zero divider, the largest divider and a disable in the middle of a phase are all covered by that comparison.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;
    localparam int TPR_W      = 7;
    localparam int REG_W      = 32;
    localparam int LOW_UNITS  = 6;
    localparam int HIGH_UNITS = 4;
endpackage

// File: rtl/scl_cfg_reg.sv
module scl_cfg_reg #(
    parameter int TPR_W = scl_gen_pkg::TPR_W,
    parameter int REG_W = scl_gen_pkg::REG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    output logic             hs_mode,
    output logic [TPR_W-1:0] eff_tpr
);
    typedef struct packed {
        logic [TPR_W-1:0] tpr;
        logic             hs;
    } cfg_t;

    localparam cfg_t CFG_RST = '{tpr: TPR_W'(1), hs: 1'b0};

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            cfg_d.tpr = wr_data[TPR_W-1:0];
            cfg_d.hs  = wr_data[TPR_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= CFG_RST;
        else        cfg_q <= cfg_d;
    end

    always_comb begin
        rd_data              = '0;
        rd_data[TPR_W-1:0]   = cfg_q.tpr;
    end

    assign hs_mode = cfg_q.hs;
    assign eff_tpr = (cfg_q.tpr == '0) ? TPR_W'(1) : cfg_q.tpr;

    // R2
    rd_follows_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (rd_data[TPR_W-1:0] == $past(wr_data[TPR_W-1:0])) && (rd_data[REG_W-1:TPR_W] == '0));

    // R3
    hs_follows_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> hs_mode == $past(wr_data[TPR_W]));

    // R7
    eff_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eff_tpr != '0);
endmodule

// File: rtl/scl_prescaler.sv
module scl_prescaler #(
    parameter int TPR_W = scl_gen_pkg::TPR_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             count_en,
    input  logic             cycle_end,
    input  logic [TPR_W-1:0] eff_tpr,
    output logic             unit_wrap
);
    localparam int PRE_W = TPR_W + 1;

    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic [TPR_W-1:0] act;
    } pre_state_t;

    localparam pre_state_t PRE_RST = '{pre: '0, act: TPR_W'(1)};

    pre_state_t st_d, st_q;
    logic [PRE_W-1:0] limit;

    // last count of a unit is 2*(1+act)-1 = 2*act+1
    assign limit     = {st_q.act, 1'b1};
    assign unit_wrap = count_en && (st_q.pre == limit);

    always_comb begin
        st_d = st_q;
        if (!count_en) begin
            st_d.pre = '0;
            st_d.act = eff_tpr;
        end else begin
            st_d.pre = unit_wrap ? '0 : st_q.pre + PRE_W'(1);
            if (cycle_end) st_d.act = eff_tpr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= PRE_RST;
        else        st_q <= st_d;
    end

    // R4
    pre_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pre <= limit);

    // R6
    act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count_en && !cycle_end) |=> $stable(st_q.act));
endmodule

// File: rtl/scl_phase_ctr.sv
module scl_phase_ctr #(
    parameter int LOW_UNITS  = scl_gen_pkg::LOW_UNITS,
    parameter int HIGH_UNITS = scl_gen_pkg::HIGH_UNITS
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic unit_wrap,
    output logic count_en,
    output logic cycle_end,
    output logic scl_o,
    output logic tick
);
    localparam int TOTAL  = LOW_UNITS + HIGH_UNITS;
    localparam int UNIT_W = $clog2(TOTAL);
    localparam logic [UNIT_W-1:0] LAST_U   = UNIT_W'(TOTAL - 1);
    localparam logic [UNIT_W-1:0] LOW_END  = UNIT_W'(LOW_UNITS - 1);
    localparam logic [UNIT_W-1:0] HIGH_BEG = UNIT_W'(LOW_UNITS);

    typedef struct packed {
        logic              run;
        logic [UNIT_W-1:0] unit;
        logic              tick;
    } ph_state_t;

    localparam ph_state_t PH_RST = '{run: 1'b0, unit: '0, tick: 1'b0};

    ph_state_t st_d, st_q;

    assign count_en  = st_q.run && enable;
    assign cycle_end = st_q.run && unit_wrap && (st_q.unit == LAST_U);

    always_comb begin
        st_d = st_q;
        st_d.tick = 1'b0;
        if (!enable) begin
            st_d = PH_RST;
        end else if (!st_q.run) begin
            st_d.run  = 1'b1;
            st_d.unit = '0;
            st_d.tick = 1'b1;
        end else if (unit_wrap) begin
            st_d.unit = (st_q.unit == LAST_U) ? '0 : st_q.unit + UNIT_W'(1);
            st_d.tick = (st_q.unit == LOW_END) || (st_q.unit == LAST_U);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= PH_RST;
        else        st_q <= st_d;
    end

    assign scl_o = !st_q.run || (st_q.unit >= HIGH_BEG);
    assign tick  = st_q.tick;

    // R5
    tick_marks_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> (scl_o != $past(scl_o)));

    // R5
    edge_has_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.run && (scl_o != $past(scl_o))) |-> tick);

    // R8
    disabled_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (scl_o && !tick));

    // R4
    unit_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.unit <= LAST_U);

    // R9
    start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !st_q.run) |=> (!scl_o && tick));
endmodule

// File: rtl/scl_clkgen_top.sv
module scl_clkgen_top #(
    parameter int TPR_W      = scl_gen_pkg::TPR_W,
    parameter int REG_W      = scl_gen_pkg::REG_W,
    parameter int LOW_UNITS  = scl_gen_pkg::LOW_UNITS,
    parameter int HIGH_UNITS = scl_gen_pkg::HIGH_UNITS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr_en,
    input  logic [REG_W-1:0] cfg_wr_data,
    output logic [REG_W-1:0] cfg_rd_data,
    input  logic             gen_enable,
    output logic             scl_o,
    output logic             phase_tick,
    output logic             hs_mode
);
    logic [TPR_W-1:0] eff_tpr;
    logic             count_en;
    logic             cycle_end;
    logic             unit_wrap;

    scl_cfg_reg #(.TPR_W(TPR_W), .REG_W(REG_W)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr_en),
        .wr_data (cfg_wr_data),
        .rd_data (cfg_rd_data),
        .hs_mode (hs_mode),
        .eff_tpr (eff_tpr)
    );

    scl_prescaler #(.TPR_W(TPR_W)) u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .count_en  (count_en),
        .cycle_end (cycle_end),
        .eff_tpr   (eff_tpr),
        .unit_wrap (unit_wrap)
    );

    scl_phase_ctr #(.LOW_UNITS(LOW_UNITS), .HIGH_UNITS(HIGH_UNITS)) u_ph (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (gen_enable),
        .unit_wrap (unit_wrap),
        .count_en  (count_en),
        .cycle_end (cycle_end),
        .scl_o     (scl_o),
        .tick      (phase_tick)
    );
endmodule

// File: tb/scl_clkgen_top_test.sv
module scl_clkgen_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [31:0] cfg_wr_data = '0;
    logic [31:0] cfg_rd_data;
    logic        gen_enable = 1'b0;
    logic        scl_o;
    logic        phase_tick;
    logic        hs_mode;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    string tag = "R1";

    // behavioural model: elapsed clocks within the serial cycle
    int  m_tpr = 1, m_hs = 0, m_run = 0, m_t = 0, m_per = 1, m_tick = 0;

    always #10 clk = ~clk;

    scl_clkgen_top uut (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
        .cfg_rd_data(cfg_rd_data), .gen_enable(gen_enable), .scl_o(scl_o),
        .phase_tick(phase_tick), .hs_mode(hs_mode)
    );

    function automatic int eff(int v);
        return (v == 0) ? 1 : v;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_tpr = 1; m_hs = 0; m_run = 0; m_t = 0; m_per = 1; m_tick = 0;
        end else begin
            int old_tpr;
            old_tpr = m_tpr;
            if (!gen_enable) begin
                m_run = 0; m_t = 0; m_per = eff(old_tpr); m_tick = 0;
            end else if (m_run == 0) begin
                m_run = 1; m_t = 0; m_per = eff(old_tpr); m_tick = 1;
            end else begin
                m_t = m_t + 1;
                if (m_t == 10 * 2 * (1 + m_per)) begin
                    m_t = 0;
                    m_per = eff(old_tpr);
                end
                m_tick = ((m_t == 0) || (m_t == 6 * 2 * (1 + m_per))) ? 1 : 0;
            end
            if (cfg_wr_en) begin
                m_tpr = int'(cfg_wr_data[6:0]);
                m_hs  = int'(cfg_wr_data[7]);
            end
        end
    end

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog: run did not finish (actual %0d cycles, expected under 150000)", cycles);
            summary();
        end
    end

    function automatic string pick(string def);
        return (tag == "R1") ? "R1" : def;
    endfunction

    task automatic compare();
        logic exp_scl;
        exp_scl = (m_run == 0) || (m_t >= 6 * 2 * (1 + m_per));
        checks++;
        if (scl_o !== exp_scl) begin
            fails++;
            $display("FAIL %s scl_o actual %b expected %b (t=%0d)", pick(tag), scl_o, exp_scl, m_t);
        end
        checks++;
        if (phase_tick !== m_tick[0]) begin
            fails++;
            $display("FAIL %s phase_tick actual %b expected %b", pick("R5"), phase_tick, m_tick[0]);
        end
        checks++;
        if (cfg_rd_data !== 32'(m_tpr)) begin
            fails++;
            $display("FAIL %s cfg_rd_data actual %h expected %h", pick("R2"), cfg_rd_data, 32'(m_tpr));
        end
        checks++;
        if (hs_mode !== m_hs[0]) begin
            fails++;
            $display("FAIL %s hs_mode actual %b expected %b", pick("R3"), hs_mode, m_hs[0]);
        end
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            compare();
        end
    endtask

    task automatic write_cfg(logic [31:0] d);
        @(negedge clk);
        compare();
        cfg_wr_en   = 1'b1;
        cfg_wr_data = d;
        @(negedge clk);
        compare();
        cfg_wr_en   = 1'b0;
        cfg_wr_data = '0;
    endtask

    initial begin
        tag = "R1";
        run(3);
        rst_n = 1'b1;
        run(3);
        tag = "R9";
        gen_enable = 1'b1;
        run(50);
        tag = "R4";
        run(400);
        tag = "R6";
        write_cfg(32'h0000_0003);
        run(320);
        write_cfg(32'h0000_0002);
        run(50);
        write_cfg(32'h0000_0004);
        run(300);
        tag = "R7";
        write_cfg(32'h0000_0000);
        run(250);
        tag = "R2";
        write_cfg(32'hFFFF_FFFF);
        run(6000);
        tag = "R3";
        write_cfg(32'h0000_0085);
        run(250);
        write_cfg(32'h0000_0005);
        run(130);
        tag = "R8";
        gen_enable = 1'b0;
        write_cfg(32'h0000_0001);
        run(40);
        tag = "R9";
        gen_enable = 1'b1;
        run(200);
        tag = "R8";
        gen_enable = 1'b0;
        run(5);
        gen_enable = 1'b1;
        run(100);
        summary();
    end
endmodule